// File: doc/BRIEF.md
# LCD Status and Interrupt Request Logic

This block keeps the display controller's status byte and produces the two interrupt requests tied to it. The video timing logic supplies the current mode and the current line number. The processor supplies writes to the status register and to a line-compare register. From these the block forms the readable status byte. That byte holds the mode, a flag that shows the current line equals the compare value, and four interrupt-enable bits. A combined status request is raised whenever an enabled condition holds. It is forced off while the display is disabled.

The status request leaves the block in two forms: a level, and a single-cycle pulse on its rising edge for a downstream flag register. A separate vertical-blank request follows entry into and exit from mode 1. When the monochrome-compatibility input is set, the block also reproduces an old-model quirk. Writing the status register during mode 0 or mode 1 raises the status request for that write, even if no enabled condition holds.

All outputs are registered. The effect of an input, or of a write, is visible in the cycle after the clock edge that samples it. The block re-evaluates on every clock, so changes of mode, line, compare value or enables all take effect with that same one-cycle latency.

Top module: `lcd_stat_irq`

## Requirements
- R1: While reset is active, and until the internal reset release, the outputs are: status byte 0x80, status request low, pulse low, vertical-blank request low.
- R2: Status bits 1:0 show the mode input sampled at the previous edge (0 horizontal blank, 1 vertical blank, 2 object search, 3 pixel transfer). Status bit 7 always reads 1.
- R3: Status bit 2 is 1 exactly when the line input sampled at the previous edge equals the compare value in effect at that edge.
- R4: A status write loads data bits 6:3 into status bits 6:3. Data bits 7 and 2:0 are ignored. Without a write, bits 6:3 keep their value.
- R5: A compare write takes effect in the same edge, so status bit 2 and the request already use the new compare value in the following cycle.
- R6: With status bit 6 set and the coincidence condition true, the status request is high in the next cycle.
- R7: Status bits 3, 4 and 5 enable the request while the mode is 0, 1 and 2 respectively. Mode 3 never raises the request by itself.
- R8: While the display-enable input is low, the status request is low in the next cycle, except when the R9 quirk applies.
- R9: With the compatibility input high, a status write while the mode is 0 or 1 drives the status request high for the next cycle. This holds whatever the enables and the display-enable input are. A write in mode 2 or 3, or with compatibility low, does not do this.
- R10: The pulse output is high for exactly the first cycle of each high period of the status request, and at no other time.
- R11: The vertical-blank request is set on entry to mode 1, stays high while the mode stays 1, and clears on any change to another mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Current display mode from the timing logic |
| line_i | input | LINE_W | Current line number |
| disp_en_i | input | 1 | Display enable; low forces the status request off |
| compat_i | input | 1 | Monochrome-compatibility mode, enables the write quirk |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_data_i | input | 8 | Status write data |
| cmp_wr_i | input | 1 | Compare register write strobe |
| cmp_data_i | input | LINE_W | Compare write data |
| stat_o | output | 8 | Readable status byte |
| stat_req_o | output | 1 | Level status interrupt request |
| stat_pulse_o | output | 1 | One-cycle pulse on the rising edge of the status request |
| vblank_req_o | output | 1 | Vertical-blank interrupt request |

## Verification
The hardest situation to reach is a collision of several events in one cycle. In that cycle a status write with the quirk active lands together with a compare write or a mode change that would raise the request on its own. Only then does the request have to stay one continuous high period with a single pulse, not two. The stimulus builds these collisions directly: status writes in each mode with compatibility on and off, compare writes that create or break coincidence in the same cycle, and display-enable toggles. A long random phase then mixes mode walks, line changes and writes with sparse strobes, and a behavioural model checks every output on each clock.

// File: rtl/lcd_stat_pkg.sv
package lcd_stat_pkg;

  localparam int MODE_W = 2;

  // number of modes that carry their own interrupt enable (modes 0..2)
  localparam int NUM_SRC_MODES = 3;

  // width of the enable field: one per source mode plus coincidence
  localparam int EN_W = NUM_SRC_MODES + 1;

  // position of the enable field inside the status byte
  localparam int EN_LSB = 2 + 1;
  localparam int EN_MSB = EN_LSB + EN_W - 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SEARCH = 2'd2,
    MODE_XFER   = 2'd3
  } lcd_mode_e;

endpackage

// File: rtl/lcd_stat_rst_sync.sv
module lcd_stat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nx;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lcd_stat_regs.sv
module lcd_stat_regs
  import lcd_stat_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [EN_W-1:0]   en_wdata,
  input  logic              cmp_wr,
  input  logic [LINE_W-1:0] cmp_wdata,
  output logic [EN_W-1:0]   en_nx,
  output logic [LINE_W-1:0] cmp_nx,
  output logic [EN_W-1:0]   en_q,
  output logic [LINE_W-1:0] cmp_q
);

  // next values include a write landing this cycle, so the
  // evaluation logic sees a write in the cycle it is made
  always_comb begin
    en_nx  = en_q;
    cmp_nx = cmp_q;
    if (stat_wr) en_nx  = en_wdata;
    if (cmp_wr)  cmp_nx = cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cmp_q <= '0;
    end else begin
      if (stat_wr) en_q  <= en_nx;
      if (cmp_wr)  cmp_q <= cmp_nx;
    end
  end

endmodule

// File: rtl/lcd_stat_cond.sv
module lcd_stat_cond
  import lcd_stat_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic [EN_W-1:0]   en,
  input  logic [LINE_W-1:0] cmp,
  input  logic [LINE_W-1:0] line,
  input  logic [MODE_W-1:0] mode,
  input  logic              disp_en,
  input  logic              compat,
  input  logic              stat_wr,
  output logic              coin,
  output logic              req_nx
);

  localparam int COIN_BIT = EN_W - 1;

  logic [NUM_SRC_MODES-1:0] mode_hit;
  logic                     coin_hit;
  logic                     cond_any;
  logic                     quirk;

  assign coin = (line == cmp);

  // one enable per source mode; mode values above the last source
  // mode have no enable and never hit
  for (genvar m = 0; m < NUM_SRC_MODES; m++) begin : g_mode_src
    assign mode_hit[m] = en[m] & (mode == MODE_W'(m));
  end

  assign coin_hit = en[COIN_BIT] & coin;

  always_comb begin
    cond_any = coin_hit | (|mode_hit);
    if (!disp_en) cond_any = 1'b0;
  end

  // compatibility quirk: a status write outside modes 2 and 3
  // raises the request regardless of enables or display enable
  assign quirk  = compat & stat_wr & ~mode[1];
  assign req_nx = cond_any | quirk;

endmodule

// File: rtl/lcd_stat_req.sv
module lcd_stat_req
  import lcd_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_nx,
  input  logic              coin_nx,
  input  logic [MODE_W-1:0] mode,
  output logic              req_q,
  output logic              pulse_q,
  output logic              coin_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              vblank_q
);

  logic pulse_nx;
  logic vblank_nx;
  logic in_vblank;
  logic was_vblank;

  assign in_vblank  = (mode == MODE_VBLANK);
  assign was_vblank = (mode_q == MODE_VBLANK);

  always_comb begin
    pulse_nx  = req_nx & ~req_q;
    vblank_nx = vblank_q;
    if (in_vblank && !was_vblank) vblank_nx = 1'b1;   // entry
    else if (!in_vblank)          vblank_nx = 1'b0;   // any exit
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      pulse_q  <= 1'b0;
      coin_q   <= 1'b0;
      mode_q   <= MODE_HBLANK;
      vblank_q <= 1'b0;
    end else begin
      req_q    <= req_nx;
      pulse_q  <= pulse_nx;
      coin_q   <= coin_nx;
      mode_q   <= mode;
      vblank_q <= vblank_nx;
    end
  end

endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
  import lcd_stat_pkg::*;
#(
  parameter int LINE_W     = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              disp_en_i,
  input  logic              compat_i,
  input  logic              stat_wr_i,
  input  logic [7:0]        stat_data_i,
  input  logic              cmp_wr_i,
  input  logic [LINE_W-1:0] cmp_data_i,
  output logic [7:0]        stat_o,
  output logic              stat_req_o,
  output logic              stat_pulse_o,
  output logic              vblank_req_o
);

  logic              rst_sync_n;
  logic [EN_W-1:0]   en_nx;
  logic [EN_W-1:0]   en_q;
  logic [LINE_W-1:0] cmp_nx;
  logic [LINE_W-1:0] cmp_q;
  logic              coin_nx;
  logic              req_nx;
  logic              coin_q;
  logic [MODE_W-1:0] mode_q;
  logic              unused_wbits;

  assign unused_wbits = ^{stat_data_i[7], stat_data_i[EN_LSB-1:0]};

  lcd_stat_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcd_stat_regs #(.LINE_W(LINE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stat_wr   (stat_wr_i),
    .en_wdata  (stat_data_i[EN_MSB:EN_LSB]),
    .cmp_wr    (cmp_wr_i),
    .cmp_wdata (cmp_data_i),
    .en_nx     (en_nx),
    .cmp_nx    (cmp_nx),
    .en_q      (en_q),
    .cmp_q     (cmp_q)
  );

  lcd_stat_cond #(.LINE_W(LINE_W)) u_cond (
    .en      (en_nx),
    .cmp     (cmp_nx),
    .line    (line_i),
    .mode    (mode_i),
    .disp_en (disp_en_i),
    .compat  (compat_i),
    .stat_wr (stat_wr_i),
    .coin    (coin_nx),
    .req_nx  (req_nx)
  );

  lcd_stat_req u_req (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_nx   (req_nx),
    .coin_nx  (coin_nx),
    .mode     (mode_i),
    .req_q    (stat_req_o),
    .pulse_q  (stat_pulse_o),
    .coin_q   (coin_q),
    .mode_q   (mode_q),
    .vblank_q (vblank_req_o)
  );

  assign stat_o = {1'b1, en_q, coin_q, mode_q};

endmodule

// File: rtl/lcd_stat_irq_chk.sv
module lcd_stat_irq_chk #(
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic [LINE_W-1:0] line_i,
  input logic              disp_en_i,
  input logic              compat_i,
  input logic              stat_wr_i,
  input logic [7:0]        stat_data_i,
  input logic              cmp_wr_i,
  input logic [LINE_W-1:0] cmp_q,
  input logic [7:0]        stat_o,
  input logic              stat_req_o,
  input logic              stat_pulse_o,
  input logic              vblank_req_o
);

  logic quirk_now;
  assign quirk_now = stat_wr_i && compat_i && !mode_i[1];

  a_r2_mode_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_o[1:0] == $past(mode_i));

  a_r2_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[7]);

  a_r3_coin_match: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_o[2] == ($past(line_i) == cmp_q));

  a_r4_write_field: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_i |=> stat_o[6:3] == $past(stat_data_i[6:3]));

  a_r4_hold_field: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_i |=> $stable(stat_o[6:3]));

  a_r6_coin_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en_i && !stat_wr_i && !cmp_wr_i && stat_o[6] && line_i == cmp_q)
    |=> stat_req_o);

  a_r7_xfer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3 && !stat_wr_i && !cmp_wr_i && !(stat_o[6] && line_i == cmp_q))
    |=> !stat_req_o);

  a_r8_disp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en_i && !quirk_now) |=> !stat_req_o);

  a_r9_quirk_raises: assert property (@(posedge clk) disable iff (!rst_n)
    quirk_now |=> stat_req_o);

  a_r10_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_req_o) |-> stat_pulse_o);

  a_r10_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pulse_o |-> stat_req_o);

  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pulse_o |=> !stat_pulse_o);

  a_r11_vblank: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> vblank_req_o == ($past(mode_i) == 2'd1));

endmodule

bind lcd_stat_irq lcd_stat_irq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mode_i       (mode_i),
  .line_i       (line_i),
  .disp_en_i    (disp_en_i),
  .compat_i     (compat_i),
  .stat_wr_i    (stat_wr_i),
  .stat_data_i  (stat_data_i),
  .cmp_wr_i     (cmp_wr_i),
  .cmp_q        (cmp_q),
  .stat_o       (stat_o),
  .stat_req_o   (stat_req_o),
  .stat_pulse_o (stat_pulse_o),
  .vblank_req_o (vblank_req_o)
);

// File: tb/lcd_stat_irq_tb.sv
`timescale 1ns/1ps
module lcd_stat_irq_tb;

  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic [LW-1:0] line;
  logic          disp;
  logic          compat;
  logic          stat_wr;
  logic [7:0]    stat_data;
  logic          cmp_wr;
  logic [LW-1:0] cmp_data;
  logic [7:0]    stat_o;
  logic          req_o;
  logic          pulse_o;
  logic          vb_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  logic [3:0]    m_en  = '0;
  logic [LW-1:0] m_cmp = '0;
  bit            m_req = 0;

  always #2 clk = ~clk;

  lcd_stat_irq #(.LINE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .line_i(line),
    .disp_en_i(disp), .compat_i(compat), .stat_wr_i(stat_wr),
    .stat_data_i(stat_data), .cmp_wr_i(cmp_wr), .cmp_data_i(cmp_data),
    .stat_o(stat_o), .stat_req_o(req_o), .stat_pulse_o(pulse_o),
    .vblank_req_o(vb_o)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // one clock of stimulus with full comparison against the model
  task automatic tick();
    logic [3:0]    nen;
    logic [LW-1:0] ncmp;
    bit co, c, q, r;
    logic [7:0] e_stat;
    nen  = stat_wr ? stat_data[6:3] : m_en;
    ncmp = cmp_wr ? cmp_data : m_cmp;
    co   = (line == ncmp);
    c    = nen[3] && co;
    case (mode)
      2'd0: if (nen[0]) c = 1;
      2'd1: if (nen[1]) c = 1;
      2'd2: if (nen[2]) c = 1;
      default: ;
    endcase
    if (!disp) c = 0;
    q = stat_wr && compat && (mode < 2);
    r = c || q;
    e_stat = {1'b1, nen, co, mode};
    @(posedge clk);
    @(negedge clk);
    chk("R2 mode", {6'd0, stat_o[1:0]}, {6'd0, e_stat[1:0]});
    chk("R2 bit7", {7'd0, stat_o[7]}, 8'd1);
    chk("R3/R5 coincidence", {7'd0, stat_o[2]}, {7'd0, e_stat[2]});
    chk("R4 enables", {4'd0, stat_o[6:3]}, {4'd0, e_stat[6:3]});
    chk("R6/R7/R8/R9 request", {7'd0, req_o}, {7'd0, r});
    chk("R10 pulse", {7'd0, pulse_o}, {7'd0, r && !m_req});
    chk("R11 vblank", {7'd0, vb_o}, {7'd0, mode == 2'd1});
    m_en = nen; m_cmp = ncmp; m_req = r;
  endtask

  task automatic wr_stat(logic [7:0] d);
    stat_wr = 1; stat_data = d; tick(); stat_wr = 0;
  endtask

  task automatic wr_cmp(logic [LW-1:0] d);
    cmp_wr = 1; cmp_data = d; tick(); cmp_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode = 0; line = 8'd5; disp = 1; compat = 0;
    stat_wr = 0; stat_data = 0; cmp_wr = 0; cmp_data = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 status", stat_o, 8'h80);
    chk("R1 request", {7'd0, req_o}, 8'd0);
    chk("R1 pulse", {7'd0, pulse_o}, 8'd0);
    chk("R1 vblank", {7'd0, vb_o}, 8'd0);
    rst_n = 1;
    repeat (4) tick();

    // R2 R11: walk the modes with nothing enabled
    for (int i = 0; i < 8; i++) begin mode = 2'(i); tick(); end
    mode = 1; tick(); tick(); mode = 0; tick();

    // R4: ignored bits written as ones, only 6:3 change
    wr_stat(8'h87); tick();
    wr_stat(8'h28); tick();
    wr_stat(8'h00); tick();

    // R3 R5 R6: coincidence enable, line sweep across compare
    wr_stat(8'h40);
    wr_cmp(8'd9);
    for (int l = 6; l < 12; l++) begin line = 8'(l); tick(); end
    line = 8'd20; cmp_wr = 1; cmp_data = 8'd20; tick(); cmp_wr = 0; tick();
    cmp_wr = 1; cmp_data = 8'd21; tick(); cmp_wr = 0; tick();
    wr_stat(8'h00);

    // R7: each mode enable in turn, mode walk including mode 3
    for (int b = 0; b < 3; b++) begin
      wr_stat(8'(8'h08 << b));
      for (int k = 0; k < 4; k++) begin mode = 2'(k); tick(); tick(); end
      mode = 0; tick();
    end

    // R8: display off with all enables and coincidence
    wr_stat(8'h78); line = 8'd21; tick();
    disp = 0; mode = 2; tick(); tick(); mode = 1; tick();
    disp = 1; tick(); wr_stat(8'h00); mode = 0; tick();

    // R9: quirk in each mode, with compat on and off, display off too
    compat = 1;
    for (int k = 0; k < 4; k++) begin
      mode = 2'(k); tick(); wr_stat(8'h00); tick(); tick();
    end
    mode = 0; disp = 0; wr_stat(8'h00); tick(); disp = 1;
    compat = 0; wr_stat(8'h00); tick();
    // R10: quirk write that also enables the current mode: one pulse
    compat = 1; mode = 0; wr_stat(8'h08); tick(); tick();
    wr_stat(8'h08); tick();
    wr_stat(8'h00); tick();
    // quirk together with a compare write making coincidence
    wr_stat(8'h40); line = 8'd30;
    stat_wr = 1; stat_data = 8'h40; cmp_wr = 1; cmp_data = 8'd30; tick();
    stat_wr = 0; cmp_wr = 0; tick(); tick();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) line = 8'($urandom_range(0, 15));
      stat_wr   = ($urandom_range(0, 9) == 0);
      stat_data = 8'($urandom);
      cmp_wr    = ($urandom_range(0, 11) == 0);
      cmp_data  = 8'($urandom_range(0, 15));
      if ($urandom_range(0, 29) == 0) disp = ~disp;
      if ($urandom_range(0, 49) == 0) compat = ~compat;
      tick();
    end
    stat_wr = 0; cmp_wr = 0; tick();

    done = 1;
    summary();
    $finish;
  end

endmodule